// File: doc/BRIEF.md
# Protection Tuple Checker

This block checks the 16-bit-guard protection tuple attached to every logical block of a multi-block transfer. A command carries the protection type, three check-enable bits, the expected application tag and its mask, the starting expected reference tag, the starting LBA and the index of the final block. Before any block is judged, the command is screened for illegal reference-check settings. Block data then streams past one word per beat. The beat that closes a block also carries that block's received tuple (guard, application tag, reference tag) and the guard value that an upstream CRC engine computed over the block.

The checker drops a block from checking when its tags hold the escape values for its type. It evaluates guard, then application tag, then reference tag. It keeps the first failure and reports one result at the end of the burst: a status code, the index of the failing block and a do-not-retry flag. The command port and the data port are both valid/ready. A command is taken only while the block is idle. Data is taken only while a command is active. Every command consumes exactly its declared number of blocks, even after a failure, so the producer never has to abort a burst. A producer may hold valid low for any number of cycles between beats. While valid is high, the beat's fields must stay stable until ready is seen.

Top module: `prot_tuple_checker`

## Requirements
- R1: After reset `cmd_ready` is 1, `dat_ready` is 0 and `res_valid` is 0.
- R2: `cmd_ready` is 1 only while idle and `dat_ready` is 1 only while a command is active. A command consumes exactly `cmd_last_blk`+1 blocks, each ended by a beat with `dat_last`=1. `res_valid` is a one-cycle pulse in the cycle after the final beat's handshake, and the block is idle in that cycle.
- R3: With type code 1 and the reference check enabled (`cmd_chk` bit 2), a starting LBA whose low 32 bits differ from `cmd_ref_tag` gives status 4 (invalid protection info), `res_dnr`=1 and block 0. The burst is still consumed.
- R4: With type code 3 and the reference check enabled, the result is status 4 with `res_dnr`=0 and block 0, whatever the tuples hold.
- R5: For type codes 0, 1 and 2, a received application tag of 0xFFFF disables every check on that block.
- R6: For type code 3, a block is exempt only when its application tag is 0xFFFF and its reference tag is 0xFFFFFFFF together.
- R7: The check-enable bits are bit 0 for guard (received vs computed), bit 1 for application tag and bit 2 for reference tag. A disabled check never fails. Within a block the first failing check in the order guard, app, ref sets the status code (1, 2 or 3). The lowest failing block index is reported. With no failure the status is 0 and `res_block` is `cmd_last_blk`. `res_dnr` is 0 for all of these.
- R8: The application tag check compares (received AND mask) with (expected AND mask).
- R9: For type codes other than 3, block n is expected to carry reference tag `cmd_ref_tag`+n modulo 2^32.
- R10: A guard failure on block 0 is forgiven when the starting LBA is 0 and every data word of block 0 is zero. Block 0 then passes and checking resumes at block 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_ptype | input | 2 | Protection type code (0..3) |
| cmd_chk | input | 3 | Check enables: bit0 guard, bit1 app, bit2 ref |
| cmd_app_tag | input | 16 | Expected application tag |
| cmd_app_mask | input | 16 | Application tag compare mask |
| cmd_ref_tag | input | 32 | Expected reference tag of block 0 |
| cmd_slba | input | 64 | Starting LBA |
| cmd_last_blk | input | 8 | Index of the final block of the burst |
| dat_valid | input | 1 | Data beat offered |
| dat_ready | output | 1 | Data beat accepted when high with dat_valid |
| dat_word | input | 32 | Block data word |
| dat_last | input | 1 | Beat closes the current block |
| tup_guard_rx | input | 16 | Received guard, read on the closing beat |
| tup_guard_calc | input | 16 | Computed guard, read on the closing beat |
| tup_app | input | 16 | Received application tag, read on the closing beat |
| tup_ref | input | 32 | Received reference tag, read on the closing beat |
| res_valid | output | 1 | One-cycle result pulse |
| res_status | output | 3 | 0 ok, 1 guard, 2 app, 3 ref, 4 invalid protection info |
| res_block | output | 8 | Index of the failing block, or final index on success |
| res_dnr | output | 1 | Do-not-retry flag |

## Verification
The assertions take for granted that `cmd_last_blk` and the type code are sampled only on the command handshake. They also assume the producer follows the handshake rules, so the checker's copy of the final index matches the burst the design counts. The bench drives each beat from the falling edge and holds it until ready is seen. It inserts idle gaps on a fixed pattern and always sends exactly the declared number of blocks. It sweeps every type code from 1 to 3, every check-enable combination and a set of fault placements, then adds directed cases for the pre-checks, forgiveness, masking and reference-tag wrap.

// File: rtl/pit_pkg.sv
package pit_pkg;
  typedef enum logic [2:0] {
    PI_OK        = 3'd0,
    PI_GUARD_ERR = 3'd1,
    PI_APP_ERR   = 3'd2,
    PI_REF_ERR   = 3'd3,
    PI_BAD_INFO  = 3'd4
  } pi_status_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } pit_state_e;

  localparam logic [1:0] PT_TYPE1 = 2'd1;
  localparam logic [1:0] PT_TYPE3 = 2'd3;

  localparam int CHK_GUARD = 0;
  localparam int CHK_APP   = 1;
  localparam int CHK_REF   = 2;
endpackage

// File: rtl/pit_precheck.sv
module pit_precheck
  import pit_pkg::*;
#(
  parameter int REF_W = 32
) (
  input  logic [1:0]       ptype,
  input  logic             chk_ref,
  input  logic [REF_W-1:0] slba_low,
  input  logic [REF_W-1:0] ref_tag,
  output logic             fail,
  output logic             dnr
);
  logic t1_mismatch;
  logic t3_refchk;

  always_comb begin
    t1_mismatch = (ptype == PT_TYPE1) && chk_ref && (slba_low != ref_tag);
    t3_refchk   = (ptype == PT_TYPE3) && chk_ref;
    fail        = t1_mismatch || t3_refchk;
    dnr         = t1_mismatch;
  end
endmodule

// File: rtl/pit_block_eval.sv
module pit_block_eval
  import pit_pkg::*;
#(
  parameter int GRD_W = 16,
  parameter int APP_W = 16,
  parameter int REF_W = 32
) (
  input  logic [1:0]       ptype,
  input  logic [2:0]       chk,
  input  logic [APP_W-1:0] exp_app,
  input  logic [APP_W-1:0] app_mask,
  input  logic [REF_W-1:0] exp_ref,
  input  logic [GRD_W-1:0] guard_rx,
  input  logic [GRD_W-1:0] guard_calc,
  input  logic [APP_W-1:0] rx_app,
  input  logic [REF_W-1:0] rx_ref,
  input  logic             forgive_ok,
  output pi_status_e       status
);
  localparam logic [APP_W-1:0] APP_ESC = {APP_W{1'b1}};
  localparam logic [REF_W-1:0] REF_ESC = {REF_W{1'b1}};

  logic app_esc, ref_esc, exempt;
  logic guard_bad, app_bad, ref_bad;

  always_comb begin
    app_esc   = (rx_app == APP_ESC);
    ref_esc   = (rx_ref == REF_ESC);
    exempt    = (ptype == PT_TYPE3) ? (app_esc && ref_esc) : app_esc;
    guard_bad = chk[CHK_GUARD] && (guard_rx != guard_calc);
    app_bad   = chk[CHK_APP] && ((rx_app & app_mask) != (exp_app & app_mask));
    ref_bad   = chk[CHK_REF] && (rx_ref != exp_ref);

    if (exempt)                     status = PI_OK;
    else if (guard_bad && forgive_ok) status = PI_OK;
    else if (guard_bad)             status = PI_GUARD_ERR;
    else if (app_bad)               status = PI_APP_ERR;
    else if (ref_bad)               status = PI_REF_ERR;
    else                            status = PI_OK;
  end
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int APP_W  = 16,
  parameter int REF_W  = 32,
  parameter int LBA_W  = 64,
  parameter int BLK_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_ptype,
  input  logic [2:0]       cmd_chk,
  input  logic [APP_W-1:0] cmd_app_tag,
  input  logic [APP_W-1:0] cmd_app_mask,
  input  logic [REF_W-1:0] cmd_ref_tag,
  input  logic [LBA_W-1:0] cmd_slba,
  input  logic [BLK_W-1:0] cmd_last_blk,
  input  logic             pre_fail,
  input  logic             pre_dnr,
  input  logic             dat_valid,
  output logic             dat_ready,
  input  logic [DATA_W-1:0] dat_word,
  input  logic             dat_last,
  input  pi_status_e       blk_status,
  output logic [1:0]       cfg_ptype,
  output logic [2:0]       cfg_chk,
  output logic [APP_W-1:0] cfg_app_tag,
  output logic [APP_W-1:0] cfg_app_mask,
  output logic [REF_W-1:0] exp_ref,
  output logic             forgive_ok,
  output logic             res_valid,
  output logic [2:0]       res_status,
  output logic [BLK_W-1:0] res_block,
  output logic             res_dnr
);
  pit_state_e       state_q;
  logic [BLK_W-1:0] blk_q, last_q;
  logic             slba_zero_q;
  logic             zero_q;
  pi_status_e       err_q;
  logic [BLK_W-1:0] err_blk_q;
  logic             err_dnr_q;

  logic cmd_fire, beat_fire, beat_zero, final_beat, run_fail;

  always_comb begin
    cmd_ready  = (state_q == ST_IDLE);
    dat_ready  = (state_q == ST_RUN) || (state_q == ST_DRAIN);
    cmd_fire   = cmd_valid && cmd_ready;
    beat_fire  = dat_valid && dat_ready;
    beat_zero  = (dat_word == '0);
    final_beat = beat_fire && dat_last && (blk_q == last_q);
    run_fail   = (state_q == ST_RUN) && (blk_status != PI_OK);
    forgive_ok = (blk_q == '0) && slba_zero_q && zero_q && beat_zero;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      blk_q        <= '0;
      last_q       <= '0;
      slba_zero_q  <= 1'b0;
      zero_q       <= 1'b1;
      err_q        <= PI_OK;
      err_blk_q    <= '0;
      err_dnr_q    <= 1'b0;
      cfg_ptype    <= '0;
      cfg_chk      <= '0;
      cfg_app_tag  <= '0;
      cfg_app_mask <= '0;
      exp_ref      <= '0;
      res_valid    <= 1'b0;
      res_status   <= PI_OK;
      res_block    <= '0;
      res_dnr      <= 1'b0;
    end else begin
      res_valid <= 1'b0;
      if (cmd_fire) begin
        cfg_ptype    <= cmd_ptype;
        cfg_chk      <= cmd_chk;
        cfg_app_tag  <= cmd_app_tag;
        cfg_app_mask <= cmd_app_mask;
        exp_ref      <= cmd_ref_tag;
        last_q       <= cmd_last_blk;
        slba_zero_q  <= (cmd_slba == '0);
        blk_q        <= '0;
        zero_q       <= 1'b1;
        err_blk_q    <= '0;
        err_dnr_q    <= pre_dnr;
        err_q        <= pre_fail ? PI_BAD_INFO : PI_OK;
        state_q      <= pre_fail ? ST_DRAIN : ST_RUN;
      end else if (beat_fire) begin
        zero_q <= dat_last ? 1'b1 : (zero_q && beat_zero);
        if (dat_last) begin
          if (final_beat) begin
            state_q   <= ST_IDLE;
            res_valid <= 1'b1;
            if (state_q == ST_RUN) begin
              res_status <= blk_status;
              res_block  <= run_fail ? blk_q : last_q;
              res_dnr    <= 1'b0;
            end else begin
              res_status <= err_q;
              res_block  <= err_blk_q;
              res_dnr    <= err_dnr_q;
            end
          end else begin
            blk_q <= blk_q + BLK_W'(1);
            if (cfg_ptype != PT_TYPE3) exp_ref <= exp_ref + REF_W'(1);
            if (run_fail) begin
              state_q   <= ST_DRAIN;
              err_q     <= blk_status;
              err_blk_q <= blk_q;
              err_dnr_q <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/prot_tuple_checker.sv
module prot_tuple_checker
  import pit_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int GRD_W  = 16,
  parameter int APP_W  = 16,
  parameter int REF_W  = 32,
  parameter int LBA_W  = 64,
  parameter int BLK_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_ptype,
  input  logic [2:0]        cmd_chk,
  input  logic [APP_W-1:0]  cmd_app_tag,
  input  logic [APP_W-1:0]  cmd_app_mask,
  input  logic [REF_W-1:0]  cmd_ref_tag,
  input  logic [LBA_W-1:0]  cmd_slba,
  input  logic [BLK_W-1:0]  cmd_last_blk,
  input  logic              dat_valid,
  output logic              dat_ready,
  input  logic [DATA_W-1:0] dat_word,
  input  logic              dat_last,
  input  logic [GRD_W-1:0]  tup_guard_rx,
  input  logic [GRD_W-1:0]  tup_guard_calc,
  input  logic [APP_W-1:0]  tup_app,
  input  logic [REF_W-1:0]  tup_ref,
  output logic              res_valid,
  output logic [2:0]        res_status,
  output logic [BLK_W-1:0]  res_block,
  output logic              res_dnr
);
  logic             pre_fail, pre_dnr, forgive_ok;
  logic [1:0]       cfg_ptype;
  logic [2:0]       cfg_chk;
  logic [APP_W-1:0] cfg_app_tag, cfg_app_mask;
  logic [REF_W-1:0] exp_ref;
  pi_status_e       blk_status;

  pit_precheck #(.REF_W(REF_W)) u_pre (
    .ptype    (cmd_ptype),
    .chk_ref  (cmd_chk[CHK_REF]),
    .slba_low (cmd_slba[REF_W-1:0]),
    .ref_tag  (cmd_ref_tag),
    .fail     (pre_fail),
    .dnr      (pre_dnr)
  );

  pit_block_eval #(.GRD_W(GRD_W), .APP_W(APP_W), .REF_W(REF_W)) u_eval (
    .ptype      (cfg_ptype),
    .chk        (cfg_chk),
    .exp_app    (cfg_app_tag),
    .app_mask   (cfg_app_mask),
    .exp_ref    (exp_ref),
    .guard_rx   (tup_guard_rx),
    .guard_calc (tup_guard_calc),
    .rx_app     (tup_app),
    .rx_ref     (tup_ref),
    .forgive_ok (forgive_ok),
    .status     (blk_status)
  );

  pit_ctrl #(
    .DATA_W(DATA_W), .APP_W(APP_W), .REF_W(REF_W), .LBA_W(LBA_W), .BLK_W(BLK_W)
  ) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_ready    (cmd_ready),
    .cmd_ptype    (cmd_ptype),
    .cmd_chk      (cmd_chk),
    .cmd_app_tag  (cmd_app_tag),
    .cmd_app_mask (cmd_app_mask),
    .cmd_ref_tag  (cmd_ref_tag),
    .cmd_slba     (cmd_slba),
    .cmd_last_blk (cmd_last_blk),
    .pre_fail     (pre_fail),
    .pre_dnr      (pre_dnr),
    .dat_valid    (dat_valid),
    .dat_ready    (dat_ready),
    .dat_word     (dat_word),
    .dat_last     (dat_last),
    .blk_status   (blk_status),
    .cfg_ptype    (cfg_ptype),
    .cfg_chk      (cfg_chk),
    .cfg_app_tag  (cfg_app_tag),
    .cfg_app_mask (cfg_app_mask),
    .exp_ref      (exp_ref),
    .forgive_ok   (forgive_ok),
    .res_valid    (res_valid),
    .res_status   (res_status),
    .res_block    (res_block),
    .res_dnr      (res_dnr)
  );
endmodule

// File: rtl/pit_checker.sv
module pit_checker #(
  parameter int BLK_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_ptype,
  input logic [BLK_W-1:0] cmd_last_blk,
  input logic             dat_ready,
  input logic             res_valid,
  input logic [2:0]       res_status,
  input logic [BLK_W-1:0] res_block,
  input logic             res_dnr
);
  logic [BLK_W-1:0] seen_last;
  logic [1:0]       seen_type;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_last <= '0;
      seen_type <= '0;
    end else if (cmd_valid && cmd_ready) begin
      seen_last <= cmd_last_blk;
      seen_type <= cmd_ptype;
    end
  end

  p_ready_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && dat_ready));

  p_result_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  p_idle_with_result_r2: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cmd_ready);

  p_dnr_only_invalid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_dnr) |-> (res_status == 3'd4));

  p_type3_no_dnr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && seen_type == 2'd3) |-> !res_dnr);

  p_block_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_block <= seen_last));

  p_success_last_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_status == 3'd0) |-> (res_block == seen_last && !res_dnr));

  p_status_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_status <= 3'd4));
endmodule

bind prot_tuple_checker pit_checker #(.BLK_W(BLK_W)) u_pit_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .cmd_ready    (cmd_ready),
  .cmd_ptype    (cmd_ptype),
  .cmd_last_blk (cmd_last_blk),
  .dat_ready    (dat_ready),
  .res_valid    (res_valid),
  .res_status   (res_status),
  .res_block    (res_block),
  .res_dnr      (res_dnr)
);

// File: tb/prot_tuple_checker_bench.sv
module prot_tuple_checker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_ptype = '0;
  logic [2:0]  cmd_chk = '0;
  logic [15:0] cmd_app_tag = '0, cmd_app_mask = '0;
  logic [31:0] cmd_ref_tag = '0;
  logic [63:0] cmd_slba = '0;
  logic [7:0]  cmd_last_blk = '0;
  logic        dat_valid = 1'b0;
  logic        dat_ready;
  logic [31:0] dat_word = '0;
  logic        dat_last = 1'b0;
  logic [15:0] tup_guard_rx = '0, tup_guard_calc = '0, tup_app = '0;
  logic [31:0] tup_ref = '0;
  logic        res_valid;
  logic [2:0]  res_status;
  logic [7:0]  res_block;
  logic        res_dnr;

  int checks = 0;
  int errors = 0;
  int beat_no = 0;

  // per-block scenario
  logic [15:0] b_grx [8];
  logic [15:0] b_gcalc [8];
  logic [15:0] b_app [8];
  logic [31:0] b_ref [8];
  logic [31:0] b_w0 [8];
  logic [31:0] b_w1 [8];

  always #2.5 clk = ~clk;

  prot_tuple_checker u_prot_tuple_checker (.*);

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic void model(output logic [2:0] st, output logic [7:0] blk, output logic dnr);
    logic [31:0] eref;
    logic        zero0;
    st = 3'd0; blk = cmd_last_blk; dnr = 1'b0;
    if (cmd_ptype == 2'd1 && cmd_chk[2] && cmd_slba[31:0] != cmd_ref_tag) begin
      st = 3'd4; blk = 8'd0; dnr = 1'b1; return;
    end
    if (cmd_ptype == 2'd3 && cmd_chk[2]) begin
      st = 3'd4; blk = 8'd0; return;
    end
    for (int b = 0; b <= int'(cmd_last_blk); b++) begin
      logic esc;
      logic gbad;
      esc = (b_app[b] == 16'hFFFF) && (cmd_ptype != 2'd3 || b_ref[b] == 32'hFFFF_FFFF);
      if (esc) continue;
      eref  = (cmd_ptype == 2'd3) ? cmd_ref_tag : cmd_ref_tag + 32'(b);
      zero0 = (b == 0) && (cmd_slba == 64'd0) && (b_w0[b] == 0) && (b_w1[b] == 0);
      gbad  = cmd_chk[0] && (b_grx[b] != b_gcalc[b]);
      if (gbad && zero0) continue;
      if (gbad) begin st = 3'd1; blk = 8'(b); return; end
      if (cmd_chk[1] && ((b_app[b] & cmd_app_mask) != (cmd_app_tag & cmd_app_mask))) begin
        st = 3'd2; blk = 8'(b); return;
      end
      if (cmd_chk[2] && b_ref[b] != eref) begin st = 3'd3; blk = 8'(b); return; end
    end
  endfunction

  task automatic beat(input logic [31:0] w, input logic last, input int b);
    beat_no++;
    if (beat_no % 3 == 0) @(negedge clk);
    dat_valid = 1'b1; dat_word = w; dat_last = last;
    tup_guard_rx = b_grx[b]; tup_guard_calc = b_gcalc[b];
    tup_app = b_app[b]; tup_ref = b_ref[b];
    while (!dat_ready) @(negedge clk);
    @(negedge clk);
    dat_valid = 1'b0; dat_last = 1'b0;
  endtask

  // runs one command with the arrays filled, checks against the model
  task automatic run_cmd(input string req);
    logic [2:0] est; logic [7:0] eblk; logic ednr;
    model(est, eblk, ednr);
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk("R2 cmd_ready low while active", 32'(cmd_ready), 32'd0);
    for (int b = 0; b <= int'(cmd_last_blk); b++) begin
      beat(b_w0[b], 1'b0, b);
      beat(b_w1[b], 1'b1, b);
    end
    chk("R2 result pulse after final beat", 32'(res_valid), 32'd1);
    chk({req, " status"}, 32'(res_status), 32'(est));
    chk({req, " block"}, 32'(res_block), 32'(eblk));
    chk({req, " dnr"}, 32'(res_dnr), 32'(ednr));
    chk("R2 idle on result", 32'({cmd_ready, dat_ready}), 32'b10);
    @(negedge clk);
    chk("R2 pulse is one cycle", 32'(res_valid), 32'd0);
  endtask

  task automatic good_blocks(input logic [31:0] ref0, input int nz);
    for (int b = 0; b < 8; b++) begin
      b_gcalc[b] = 16'h1000 + 16'(b * 7);
      b_grx[b]   = b_gcalc[b];
      b_app[b]   = cmd_app_tag ^ 16'h00F0;   // differs only outside the mask (R8)
      b_ref[b]   = (cmd_ptype == 2'd3) ? ref0 : ref0 + 32'(b);
      b_w0[b]    = nz ? 32'hA5A5_0000 + 32'(b) : 32'd0;
      b_w1[b]    = 32'd0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 cmd_ready after reset", 32'(cmd_ready), 32'd1);
    chk("R1 dat_ready after reset", 32'(dat_ready), 32'd0);
    chk("R1 res_valid after reset", 32'(res_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep: type 1..3, all enable combinations, fault placements (R5 R6 R7 R8 R9)
    for (int t = 1; t <= 3; t++) begin
      for (int c = 0; c < 8; c++) begin
        for (int f = 0; f < 7; f++) begin
          logic [31:0] ref0;
          ref0 = (f % 2 == 0) ? 32'hFFFF_FFFE : 32'h0000_1234;  // wrap covers R9
          cmd_ptype = 2'(t); cmd_chk = 3'(c);
          cmd_app_tag = 16'h5A3C; cmd_app_mask = 16'hFF0F;
          cmd_ref_tag = ref0; cmd_slba = {32'h0000_0001, ref0};
          cmd_last_blk = 8'd3;
          good_blocks(ref0, 1);
          case (f)
            1: b_grx[1] = ~b_grx[1];
            2: begin b_app[2] = b_app[2] ^ 16'h0100; b_grx[3] = ~b_grx[3]; end
            3: begin b_app[1] = b_app[1] ^ 16'h0001; b_ref[1] = b_ref[1] + 1; end
            4: begin b_app[0] = 16'hFFFF; b_grx[0] = ~b_grx[0]; b_ref[0] = ~b_ref[0]; end
            5: begin b_app[2] = 16'hFFFF; b_ref[2] = 32'hFFFF_FFFF; b_grx[2] = ~b_grx[2]; end
            6: begin b_grx[3] = ~b_grx[3]; b_app[3] = ~b_app[3]; b_ref[3] = b_ref[3] ^ 32'h8; end
            default: ;
          endcase
          run_cmd("R7 sweep");
        end
      end
    end

    // R3: type 1 LBA/ref mismatch with ref check on
    cmd_ptype = 2'd1; cmd_chk = 3'b111; cmd_ref_tag = 32'h10; cmd_slba = 64'h11;
    cmd_last_blk = 8'd1; good_blocks(32'h10, 1);
    run_cmd("R3 precheck mismatch");
    // R3: only low 32 bits compared
    cmd_slba = 64'hABCD_0000_0000_0010;
    run_cmd("R3 upper LBA bits ignored");
    // R4: type 3 with ref check
    cmd_ptype = 2'd3; cmd_chk = 3'b100; cmd_slba = 64'h10; good_blocks(32'h10, 1);
    run_cmd("R4 type3 ref check");
    // R10 forgiveness on zero block 0 at LBA 0
    cmd_ptype = 2'd2; cmd_chk = 3'b111; cmd_ref_tag = 32'h0; cmd_slba = 64'd0;
    cmd_last_blk = 8'd2; good_blocks(32'h0, 0);
    b_grx[0] = ~b_grx[0];
    run_cmd("R10 forgiven");
    b_w1[0] = 32'h1;
    run_cmd("R10 nonzero data not forgiven");
    b_w1[0] = 32'h0; cmd_slba = 64'd5; cmd_ptype = 2'd2;
    run_cmd("R10 nonzero LBA not forgiven");
    cmd_slba = 64'd0; b_grx[0] = b_gcalc[0]; b_grx[1] = ~b_grx[1];
    run_cmd("R10 only block 0 forgiven");
    // R10 forgiven block 0, later app failure still reported
    b_grx[1] = b_gcalc[1]; b_grx[0] = ~b_grx[0]; b_app[2] = ~b_app[2];
    run_cmd("R10 checking resumes");
    // R8: bit inside mask
    cmd_ptype = 2'd2; cmd_chk = 3'b010; cmd_app_mask = 16'h0001; cmd_slba = 64'd9;
    good_blocks(32'h0, 1); b_app[1] = cmd_app_tag ^ 16'hFFFE;
    run_cmd("R8 masked equal");
    b_app[1] = cmd_app_tag ^ 16'h0001;
    run_cmd("R8 masked differ");
    // single-block burst
    cmd_last_blk = 8'd0; good_blocks(32'h0, 1);
    run_cmd("R2 single block");
    @(negedge clk);
    chk("R2 dat_ready low when idle", 32'(dat_ready), 32'd0);
    finish_run();
  end
endmodule